// File: doc/BRIEF.md
# Address-Match Busy Arbiter with Write Inhibit

This block sits beside a two-port memory array. It watches the select, write and address inputs of both ports. When both ports select the same word at the same time, it lets one port go ahead and raises an active-low busy flag toward the other. The flagged port's write strobe is gated off inside the block, so a colliding write never reaches the array. A read made while its port is flagged still goes through, but it may return the word as it was before the other port's write in progress.

Each port keeps a record of its previous select and address. This tells the arbiter which side was already steady when the collision began, and that side wins. When both sides begin colliding on the same clock edge, a fixed rule decides, and by default the left port wins. Once a decision is made it holds until the collision ends.

In follower mode the block makes no decision of its own. Its busy outputs stay high. A pair of externally supplied busy inputs then act only as write inhibits. Several such blocks placed side by side for a wider word can then follow one deciding instance.

Top module: `dpm_contention_arb`

## Requirements
- R1: When either select is low or the two addresses differ at a clock edge, both busy outputs are high after that edge.
- R2: When a collision begins, the port that already had the same select and address at the previous edge wins. The other port's busy output goes low right after the edge at which the collision is first seen.
- R3: The two busy outputs are never low together.
- R4: The write inputs play no part in the decision. The same select and address history gives the same busy outputs, whether the ports are reading or writing.
- R5: A port's write-enable output (select high and write high) is forced low in every cycle in which that port is flagged busy.
- R6: With `follower_mode` high, both busy outputs stay high. Each port's write-enable output is its select AND write AND its external busy input (low means inhibit). With `follower_mode` low, the external busy inputs are ignored.
- R7: When neither colliding port was steady at the previous edge, or both were, the left port wins (TIE_LEFT = 1).
- R8: A busy flag stays on the same port while the collision lasts. It is released right after the first edge at which the collision ends.
- R9: Reset (active-low, asynchronous) returns both busy outputs to high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| follower_mode | input | 1 | 1: no arbitration; the external busy inputs inhibit writes |
| lt_sel | input | 1 | Left port select, active high |
| lt_wr | input | 1 | Left port write request, active high |
| lt_addr | input | ADDR_W | Left port word address |
| rt_sel | input | 1 | Right port select, active high |
| rt_wr | input | 1 | Right port write request, active high |
| rt_addr | input | ADDR_W | Right port word address |
| lt_busy_in_n | input | 1 | External left busy, active low, used in follower mode |
| rt_busy_in_n | input | 1 | External right busy, active low, used in follower mode |
| lt_busy_n | output | 1 | Left busy flag, active low, registered |
| rt_busy_n | output | 1 | Right busy flag, active low, registered |
| lt_wr_en | output | 1 | Gated left write strobe toward the array |
| rt_wr_en | output | 1 | Gated right write strobe toward the array |

## Verification
A wrong winner register shows up on the busy outputs one edge after the fault. It then shows up straight away on the write-enable of the port that should have been blocked or let through. A stale steadiness record turns into a wrong winner on the first collision that follows. This is why the stimulus enters collisions from each side in turn, through both kinds of tie, and through a return from follower mode while the ports are already colliding. Hold and release are checked on the edge after the collision ends by an address change and again after it ends by a select drop.

// File: rtl/dpm_arb_pkg.sv
package dpm_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE      = 2'b00,
      ARB_LEFT_WON  = 2'b01,
      ARB_RIGHT_WON = 2'b10
   } arb_state_t;

   localparam int NUM_PORTS = 2;
   localparam int PORT_L    = 0;
   localparam int PORT_R    = 1;
endpackage

// File: rtl/dpm_arb_track.sv
// Remembers last-edge select/address of one port; flags a steady request.
module dpm_arb_track #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   output logic              steady
);
   logic              sel_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         sel_q  <= sel;
         addr_q <= addr;
      end
   end

   assign steady = sel & sel_q & (addr == addr_q);
endmodule

// File: rtl/dpm_arb_core.sv
// Collision detect and winner register.
module dpm_arb_core
   import dpm_arb_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 follower_mode,
   input  logic                 sel_l,
   input  logic                 sel_r,
   input  logic [ADDR_W-1:0]    addr_l,
   input  logic [ADDR_W-1:0]    addr_r,
   input  logic [NUM_PORTS-1:0] steady,
   output logic [NUM_PORTS-1:0] busy_n
);
   arb_state_t state_q, state_d, tie_state;
   logic       collide;

   generate
      if (TIE_LEFT) begin : g_tie_left
         assign tie_state = ARB_LEFT_WON;
      end else begin : g_tie_right
         assign tie_state = ARB_RIGHT_WON;
      end
   endgenerate

   assign collide = sel_l & sel_r & (addr_l == addr_r);

   always_comb begin
      state_d = state_q;
      if (follower_mode || !collide) begin
         state_d = ARB_IDLE;
      end else if (state_q == ARB_IDLE) begin
         if (steady[PORT_L] && !steady[PORT_R])
            state_d = ARB_LEFT_WON;
         else if (steady[PORT_R] && !steady[PORT_L])
            state_d = ARB_RIGHT_WON;
         else
            state_d = tie_state;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   assign busy_n[PORT_L] = (state_q != ARB_RIGHT_WON);
   assign busy_n[PORT_R] = (state_q != ARB_LEFT_WON);
endmodule

// File: rtl/dpm_arb_wgate.sv
// Write strobe gate: internal busy when deciding, external busy when following.
module dpm_arb_wgate (
   input  logic follower_mode,
   input  logic sel,
   input  logic wr,
   input  logic busy_int_n,
   input  logic busy_ext_n,
   output logic wr_en
);
   logic allow;
   assign allow = follower_mode ? busy_ext_n : busy_int_n;
   assign wr_en = sel & wr & allow;
endmodule

// File: rtl/dpm_contention_arb.sv
module dpm_contention_arb
   import dpm_arb_pkg::*;
#(
   parameter int ADDR_W   = 11,
   parameter bit TIE_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              follower_mode,
   input  logic              lt_sel,
   input  logic              lt_wr,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              rt_sel,
   input  logic              rt_wr,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              lt_busy_in_n,
   input  logic              rt_busy_in_n,
   output logic              lt_busy_n,
   output logic              rt_busy_n,
   output logic              lt_wr_en,
   output logic              rt_wr_en
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_width
         $error("dpm_contention_arb: ADDR_W must be in 1..32");
      end
   endgenerate

   logic              sel_v    [NUM_PORTS];
   logic              wr_v     [NUM_PORTS];
   logic [ADDR_W-1:0] addr_v   [NUM_PORTS];
   logic              bext_v   [NUM_PORTS];
   logic              wen_v    [NUM_PORTS];
   logic [NUM_PORTS-1:0] steady;
   logic [NUM_PORTS-1:0] busy_n;

   assign sel_v[PORT_L]  = lt_sel;        assign sel_v[PORT_R]  = rt_sel;
   assign wr_v[PORT_L]   = lt_wr;         assign wr_v[PORT_R]   = rt_wr;
   assign addr_v[PORT_L] = lt_addr;       assign addr_v[PORT_R] = rt_addr;
   assign bext_v[PORT_L] = lt_busy_in_n;  assign bext_v[PORT_R] = rt_busy_in_n;

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         dpm_arb_track #(.ADDR_W(ADDR_W)) u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel    (sel_v[p]),
            .addr   (addr_v[p]),
            .steady (steady[p])
         );
         dpm_arb_wgate u_wgate (
            .follower_mode (follower_mode),
            .sel           (sel_v[p]),
            .wr            (wr_v[p]),
            .busy_int_n    (busy_n[p]),
            .busy_ext_n    (bext_v[p]),
            .wr_en         (wen_v[p])
         );
      end
   endgenerate

   dpm_arb_core #(.ADDR_W(ADDR_W), .TIE_LEFT(TIE_LEFT)) u_core (
      .clk           (clk),
      .rst_n         (rst_n),
      .follower_mode (follower_mode),
      .sel_l         (lt_sel),
      .sel_r         (rt_sel),
      .addr_l        (lt_addr),
      .addr_r        (rt_addr),
      .steady        (steady),
      .busy_n        (busy_n)
   );

   assign lt_busy_n = busy_n[PORT_L];
   assign rt_busy_n = busy_n[PORT_R];
   assign lt_wr_en  = wen_v[PORT_L];
   assign rt_wr_en  = wen_v[PORT_R];
endmodule

// File: rtl/dpm_arb_chk.sv
module dpm_arb_chk #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              follower_mode,
   input logic              lt_sel,
   input logic [ADDR_W-1:0] lt_addr,
   input logic              rt_sel,
   input logic [ADDR_W-1:0] rt_addr,
   input logic              lt_busy_in_n,
   input logic              rt_busy_in_n,
   input logic              lt_busy_n,
   input logic              rt_busy_n,
   input logic              lt_wr_en,
   input logic              rt_wr_en
);
   logic collide;
   assign collide = lt_sel & rt_sel & (lt_addr == rt_addr);

   assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (follower_mode || !collide) |=> (lt_busy_n && rt_busy_n));

   assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!lt_busy_n && !rt_busy_n));

   assert_lt_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!follower_mode && !lt_busy_n) |-> !lt_wr_en);

   assert_rt_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!follower_mode && !rt_busy_n) |-> !rt_wr_en);

   assert_lt_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (follower_mode && !lt_busy_in_n) |-> !lt_wr_en);

   assert_rt_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (follower_mode && !rt_busy_in_n) |-> !rt_wr_en);

   assert_lt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!follower_mode && collide && !lt_busy_n) |=> !lt_busy_n);

   assert_rt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!follower_mode && collide && !rt_busy_n) |=> !rt_busy_n);
endmodule

bind dpm_contention_arb dpm_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .follower_mode (follower_mode),
   .lt_sel        (lt_sel),
   .lt_addr       (lt_addr),
   .rt_sel        (rt_sel),
   .rt_addr       (rt_addr),
   .lt_busy_in_n  (lt_busy_in_n),
   .rt_busy_in_n  (rt_busy_in_n),
   .lt_busy_n     (lt_busy_n),
   .rt_busy_n     (rt_busy_n),
   .lt_wr_en      (lt_wr_en),
   .rt_wr_en      (rt_wr_en)
);

// File: tb/dpm_contention_arb_tb.sv
module dpm_contention_arb_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 11;

   typedef struct packed {
      logic [3:0]    req;
      logic          fol;
      logic          ls, lw;
      logic [AW-1:0] la;
      logic          rs, rw;
      logic [AW-1:0] ra;
      logic          lbi, rbi;
      logic [3:0]    exp;   // {lt_busy_n, rt_busy_n, lt_wr_en, rt_wr_en}
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{4'd9, 1'b0, 1'b0,1'b0,11'h000, 1'b0,1'b0,11'h000, 1'b1,1'b1, 4'b1100}, // R9 idle
      '{4'd1, 1'b0, 1'b1,1'b0,11'h123, 1'b0,1'b0,11'h000, 1'b1,1'b1, 4'b1100}, // R1 one side only
      '{4'd2, 1'b0, 1'b1,1'b0,11'h123, 1'b1,1'b1,11'h123, 1'b1,1'b1, 4'b1000}, // R2 right late
      '{4'd5, 1'b0, 1'b1,1'b1,11'h123, 1'b1,1'b1,11'h123, 1'b1,1'b1, 4'b1010}, // R5 right write blocked
      '{4'd8, 1'b0, 1'b1,1'b1,11'h123, 1'b1,1'b1,11'h124, 1'b1,1'b1, 4'b1111}, // R8 release on addr change
      '{4'd4, 1'b0, 1'b1,1'b1,11'h123, 1'b1,1'b0,11'h123, 1'b1,1'b1, 4'b1010}, // R4 reading loser same result
      '{4'd8, 1'b0, 1'b0,1'b0,11'h123, 1'b1,1'b0,11'h123, 1'b1,1'b1, 4'b1100}, // R8 release on select drop
      '{4'd2, 1'b0, 1'b1,1'b0,11'h123, 1'b1,1'b0,11'h123, 1'b1,1'b1, 4'b0100}, // R2 left late
      '{4'd5, 1'b0, 1'b1,1'b1,11'h123, 1'b1,1'b0,11'h123, 1'b1,1'b1, 4'b0100}, // R5 left write blocked
      '{4'd1, 1'b0, 1'b0,1'b0,11'h000, 1'b0,1'b0,11'h000, 1'b1,1'b1, 4'b1100}, // R1 both off
      '{4'd7, 1'b0, 1'b1,1'b1,11'h7FF, 1'b1,1'b1,11'h7FF, 1'b1,1'b1, 4'b1010}, // R7 same-edge tie
      '{4'd1, 1'b0, 1'b0,1'b0,11'h000, 1'b0,1'b0,11'h000, 1'b1,1'b1, 4'b1100}, // R1
      '{4'd1, 1'b0, 1'b1,1'b1,11'h000, 1'b1,1'b1,11'h7FF, 1'b1,1'b1, 4'b1111}, // R1 addresses differ
      '{4'd6, 1'b1, 1'b1,1'b1,11'h200, 1'b1,1'b1,11'h200, 1'b1,1'b1, 4'b1111}, // R6 follower, no inhibit
      '{4'd6, 1'b1, 1'b1,1'b1,11'h200, 1'b1,1'b1,11'h200, 1'b0,1'b1, 4'b1101}, // R6 left inhibited
      '{4'd6, 1'b1, 1'b1,1'b1,11'h200, 1'b1,1'b1,11'h200, 1'b1,1'b0, 4'b1110}, // R6 right inhibited
      '{4'd7, 1'b0, 1'b1,1'b1,11'h200, 1'b1,1'b1,11'h200, 1'b1,1'b1, 4'b1010}, // R7 both steady tie
      '{4'd6, 1'b0, 1'b1,1'b1,11'h200, 1'b1,1'b1,11'h200, 1'b0,1'b0, 4'b1010}, // R6 ext busy ignored
      '{4'd1, 1'b0, 1'b0,1'b0,11'h000, 1'b0,1'b0,11'h000, 1'b1,1'b1, 4'b1100}  // R1
   };

   logic clk = 1'b0, rst_n = 1'b0, fol = 1'b0;
   logic ls = 1'b0, lw = 1'b0, rs = 1'b0, rw = 1'b0, lbi = 1'b1, rbi = 1'b1;
   logic [AW-1:0] la = '0, ra = '0;
   logic lb, rb, lwe, rwe;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpm_contention_arb #(.ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .follower_mode(fol),
      .lt_sel(ls), .lt_wr(lw), .lt_addr(la),
      .rt_sel(rs), .rt_wr(rw), .rt_addr(ra),
      .lt_busy_in_n(lbi), .rt_busy_in_n(rbi),
      .lt_busy_n(lb), .rt_busy_n(rb), .lt_wr_en(lwe), .rt_wr_en(rwe)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      fol = v.fol; ls = v.ls; lw = v.lw; la = v.la;
      rs = v.rs; rw = v.rw; ra = v.ra; lbi = v.lbi; rbi = v.rbi;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9 busy during reset", {lb, rb, 2'b00}, 4'b1100);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(VEC[i]);
         @(posedge clk);
         #1;
         check($sformatf("R%0d vec%0d", VEC[i].req, i), {lb, rb, lwe, rwe}, VEC[i].exp);
      end
      // r8_ and r3_: right arrives late, busy held for several cycles
      @(negedge clk);
      ls = 1'b1; la = 11'h055; lw = 1'b0; rs = 1'b0;
      @(negedge clk);
      rs = 1'b1; ra = 11'h055; rw = 1'b1;
      for (int k = 0; k < 4; k++) begin
         @(posedge clk); #1;
         check("R8 hold on right", {lb, rb, lwe, rwe}, 4'b1000);
      end
      // R9: asynchronous reset mid-collision releases busy at once
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 async reset", {lb, rb, 2'b00}, 4'b1100);
      @(negedge clk);
      rst_n = 1'b1;
      ls = 1'b0; rs = 1'b0; lw = 1'b0; rw = 1'b0;
      @(posedge clk); #1;
      check("R1 after reset", {lb, rb, lwe, rwe}, 4'b1100);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule